// File: doc/BRIEF.md
# Set-Associative Tag Lookup with Shared-Row Storage

This block holds the tags of an N-way set-associative cache and answers hit or miss questions about them. All ways of one set live side by side in a single wide memory row. Each way's slot is a tag plus a valid bit. A lookup request supplies an index and a tag. The block maps the index onto a set and reads the full row synchronously. One cycle later it compares every way's slot with the request tag in parallel. The result is a one-hot hit vector, ready to steer a one-hot data multiplexer, together with a hit flag and the encoded way number.

A separate update port rewrites one slot, chosen by a way number, in one set. It does this with a per-way write mask on the shared row, so it finishes in one cycle and leaves the other ways of that row untouched. After reset, a sequencer invalidates the sets one per cycle and holds the request side not-ready until it has finished. Lookups may be issued on every cycle once ready is high.

Top module: `tagq_lookup`

## Requirements
- R1: After reset is released, `lkp_ready_o` stays low for exactly SETS cycles while every set is invalidated. It then goes high, and every lookup misses until a slot is written.
- R2: The set addressed by a lookup or an update is the request index modulo SETS. Two indices that differ by a multiple of SETS reach the same row.
- R3: A lookup accepted on a clock edge (`lkp_valid_i` and `lkp_ready_o` both high) raises `rsp_valid_o` for exactly the following cycle. A request can be accepted on every consecutive cycle, and each response belongs to the request of the previous edge.
- R4: On a response, bit w of `rsp_hit_vec_o` is 1 when way w's slot in the addressed set is valid and its tag equals the request tag. When such a way exists, `rsp_hit_o` is 1 and `rsp_way_o` holds w as an unsigned binary number.
- R5: A way whose slot is invalid never hits, even when its stored tag field equals the request tag. An update with `upd_valid_i` low invalidates the chosen slot.
- R6: An update (`upd_en_i` high while ready) writes `upd_tag_i` and `upd_valid_i` into way `upd_way_i` of the addressed set only. Every other way of that set, and every other set, keeps its contents.
- R7: When an update and an accepted lookup address the same set on the same edge, the lookup reports the row as it was before the update. The next lookup sees the new contents.
- R8: A lookup presented while `lkp_ready_o` is low is not accepted and produces no response.
- R9: When no two valid ways of a set hold the same tag, `rsp_hit_vec_o` has at most one bit set. Outside a response cycle, `rsp_hit_vec_o` and `rsp_hit_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously to clk |
| lkp_valid_i | input | 1 | Lookup request present |
| lkp_ready_o | output | 1 | Lookup side can accept a request (low during the reset flush) |
| lkp_idx_i | input | IDX_W | Lookup index, reduced modulo SETS |
| lkp_tag_i | input | TAG_W | Tag to match |
| upd_en_i | input | 1 | Write one slot this cycle |
| upd_idx_i | input | IDX_W | Update index, reduced modulo SETS |
| upd_way_i | input | WAY_W | Way whose slot is written |
| upd_tag_i | input | TAG_W | Tag written into the slot |
| upd_valid_i | input | 1 | Valid bit written into the slot |
| rsp_valid_o | output | 1 | Response present, one cycle after acceptance |
| rsp_hit_vec_o | output | WAYS | One-hot per-way hit vector |
| rsp_hit_o | output | 1 | Some way hit |
| rsp_way_o | output | WAY_W | Number of the hitting way |

## Verification
The embedded properties watch the timing and structure of every cycle. They check that a response follows each accepted request by exactly one cycle and never appears otherwise, that the flush counter steps through the sets and stops at the last one, that an update mask never selects more than one way, that the hit vector stays one-hot, and that the encoded way points at a set bit. Only the bench's scenarios can show the stored contents. These cover misses after the flush, hits on the correct way after updates, index aliasing modulo SETS, the untouched neighbour ways, invalidation, and the read-before-write result when an update and a lookup share a set on the same edge.

// File: rtl/tagq_pkg.sv
package tagq_pkg;

  // Flush sequencer states
  typedef enum logic [0:0] {
    FL_RUN   = 1'b0,
    FL_CLEAR = 1'b1
  } flush_st_e;

  // Width of a field that numbers n items; never below one bit
  function automatic int unsigned num_bits(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/tagq_flush_seq.sv
module tagq_flush_seq
  import tagq_pkg::*;
#(
  parameter int unsigned SETS  = 16,
  parameter int unsigned SET_W = num_bits(SETS)
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic             busy_o,
  output logic [SET_W-1:0] set_o
);

  localparam logic [SET_W-1:0] LAST_SET = SET_W'(SETS - 1);

  flush_st_e        state_q, state_d;
  logic [SET_W-1:0] cnt_q, cnt_d;

  // next state
  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    if (state_q == FL_CLEAR) begin
      if (cnt_q == LAST_SET) begin
        state_d = FL_RUN;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= FL_CLEAR;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign busy_o = (state_q == FL_CLEAR);
  assign set_o  = cnt_q;

  AST_FLUSH_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && cnt_q != LAST_SET) |=> (busy_o && cnt_q == $past(cnt_q) + 1'b1)); // R1

  AST_FLUSH_END: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && cnt_q == LAST_SET) |=> !busy_o); // R1

  AST_FLUSH_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |=> !busy_o); // R1

endmodule

// File: rtl/tagq_row_store.sv
module tagq_row_store
  import tagq_pkg::*;
#(
  parameter int unsigned SETS  = 16,
  parameter int unsigned WAYS  = 4,
  parameter int unsigned EW    = 9,
  parameter int unsigned SET_W = num_bits(SETS)
) (
  input  logic                 clk,
  input  logic                 wr_en_i,
  input  logic [SET_W-1:0]     wr_set_i,
  input  logic [WAYS-1:0]      wr_mask_i,
  input  logic [WAYS*EW-1:0]   wr_row_i,
  input  logic                 rd_en_i,
  input  logic [SET_W-1:0]     rd_set_i,
  output logic [WAYS*EW-1:0]   rd_row_o
);

  localparam int unsigned ROW_W = WAYS * EW;

  logic [ROW_W-1:0] mem_q [SETS];
  logic [ROW_W-1:0] rd_row_q;

  // Masked write and registered read share one edge; the read register
  // samples the row before the write lands (read-before-write).
  always_ff @(posedge clk) begin
    if (wr_en_i) begin
      for (int w = 0; w < WAYS; w++) begin
        if (wr_mask_i[w]) begin
          mem_q[wr_set_i][w*EW +: EW] <= wr_row_i[w*EW +: EW];
        end
      end
    end
    if (rd_en_i) begin
      rd_row_q <= mem_q[rd_set_i];
    end
  end

  assign rd_row_o = rd_row_q;

endmodule

// File: rtl/tagq_way_match.sv
module tagq_way_match
  import tagq_pkg::*;
#(
  parameter int unsigned WAYS  = 4,
  parameter int unsigned TAG_W = 8,
  parameter int unsigned EW    = TAG_W + 1,
  parameter int unsigned WAY_W = num_bits(WAYS)
) (
  input  logic [WAYS*EW-1:0] row_i,
  input  logic [TAG_W-1:0]   tag_i,
  input  logic               en_i,
  output logic [WAYS-1:0]    hit_vec_o,
  output logic               hit_o,
  output logic [WAY_W-1:0]   way_o
);

  // One comparator per way; slot layout is {valid, tag}
  for (genvar w = 0; w < WAYS; w++) begin : g_way
    logic [EW-1:0]    slot;
    logic             slot_vld;
    logic [TAG_W-1:0] slot_tag;
    assign slot      = row_i[w*EW +: EW];
    assign slot_vld  = slot[EW-1];
    assign slot_tag  = slot[TAG_W-1:0];
    assign hit_vec_o[w] = en_i && slot_vld && (slot_tag == tag_i);
  end

  assign hit_o = |hit_vec_o;

  always_comb begin
    way_o = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (hit_vec_o[w]) begin
        way_o = WAY_W'(w);
      end
    end
  end

endmodule

// File: rtl/tagq_lookup.sv
module tagq_lookup
  import tagq_pkg::*;
#(
  parameter int unsigned WAYS  = 4,
  parameter int unsigned SETS  = 16,
  parameter int unsigned TAG_W = 8,
  parameter int unsigned IDX_W = 8,
  parameter int unsigned WAY_W = num_bits(WAYS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lkp_valid_i,
  output logic             lkp_ready_o,
  input  logic [IDX_W-1:0] lkp_idx_i,
  input  logic [TAG_W-1:0] lkp_tag_i,
  input  logic             upd_en_i,
  input  logic [IDX_W-1:0] upd_idx_i,
  input  logic [WAY_W-1:0] upd_way_i,
  input  logic [TAG_W-1:0] upd_tag_i,
  input  logic             upd_valid_i,
  output logic             rsp_valid_o,
  output logic [WAYS-1:0]  rsp_hit_vec_o,
  output logic             rsp_hit_o,
  output logic [WAY_W-1:0] rsp_way_o
);

  localparam int unsigned SET_W = num_bits(SETS);
  localparam int unsigned EW    = TAG_W + 1;
  localparam int unsigned ROW_W = WAYS * EW;
  localparam logic [IDX_W-1:0] SETS_IDX = IDX_W'(SETS);

  logic             flush_busy;
  logic [SET_W-1:0] flush_set;
  logic [SET_W-1:0] lkp_set, upd_set;
  logic             lkp_accept;

  logic             wr_en;
  logic [SET_W-1:0] wr_set;
  logic [WAYS-1:0]  wr_mask;
  logic [ROW_W-1:0] wr_row;
  logic [ROW_W-1:0] rd_row;

  logic             s1_vld_q, s1_vld_d;
  logic [TAG_W-1:0] s1_tag_q, s1_tag_d;

  tagq_flush_seq #(
    .SETS  (SETS),
    .SET_W (SET_W)
  ) flush_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .busy_o (flush_busy),
    .set_o  (flush_set)
  );

  // index folding
  assign lkp_set = SET_W'(lkp_idx_i % SETS_IDX);
  assign upd_set = SET_W'(upd_idx_i % SETS_IDX);

  assign lkp_ready_o = !flush_busy;
  assign lkp_accept  = lkp_valid_i && lkp_ready_o;

  // write-port owner: flush first, then the update port
  always_comb begin
    if (flush_busy) begin
      wr_en   = 1'b1;
      wr_set  = flush_set;
      wr_mask = '1;
      wr_row  = '0;
    end else begin
      wr_en   = upd_en_i;
      wr_set  = upd_set;
      wr_mask = WAYS'(1) << upd_way_i;
      wr_row  = {WAYS{upd_valid_i, upd_tag_i}};
    end
  end

  tagq_row_store #(
    .SETS  (SETS),
    .WAYS  (WAYS),
    .EW    (EW),
    .SET_W (SET_W)
  ) store_i (
    .clk       (clk),
    .wr_en_i   (wr_en),
    .wr_set_i  (wr_set),
    .wr_mask_i (wr_mask),
    .wr_row_i  (wr_row),
    .rd_en_i   (lkp_accept),
    .rd_set_i  (lkp_set),
    .rd_row_o  (rd_row)
  );

  // compare-stage next state
  always_comb begin
    s1_vld_d = lkp_accept;
    s1_tag_d = lkp_accept ? lkp_tag_i : s1_tag_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_vld_q <= 1'b0;
      s1_tag_q <= '0;
    end else begin
      s1_vld_q <= s1_vld_d;
      s1_tag_q <= s1_tag_d;
    end
  end

  tagq_way_match #(
    .WAYS  (WAYS),
    .TAG_W (TAG_W),
    .EW    (EW),
    .WAY_W (WAY_W)
  ) match_i (
    .row_i     (rd_row),
    .tag_i     (s1_tag_q),
    .en_i      (s1_vld_q),
    .hit_vec_o (rsp_hit_vec_o),
    .hit_o     (rsp_hit_o),
    .way_o     (rsp_way_o)
  );

  assign rsp_valid_o = s1_vld_q;

  AST_RSP_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (lkp_valid_i && lkp_ready_o) |=> rsp_valid_o); // R3

  AST_NO_RSP_UNACCEPTED: assert property (@(posedge clk) disable iff (!rst_n)
    !(lkp_valid_i && lkp_ready_o) |=> !rsp_valid_o); // R8

  AST_HIT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rsp_hit_vec_o)); // R9

  AST_IDLE_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid_o |-> (!rsp_hit_o && rsp_hit_vec_o == '0)); // R9

  AST_HIT_WAY_POINTS: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_hit_o |-> rsp_hit_vec_o[rsp_way_o]); // R4

  AST_UPD_ONE_WAY: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en_i && lkp_ready_o) |-> ($countones(wr_mask) <= 1)); // R6

endmodule

// File: tb/tagq_lookup_tb_top.sv
module tagq_lookup_tb_top;

  localparam int unsigned WAYS  = 4;
  localparam int unsigned SETS  = 16;
  localparam int unsigned TAG_W = 8;
  localparam int unsigned IDX_W = 8;
  localparam int unsigned WAY_W = 2;

  logic             clk;
  logic             rst_n;
  logic             lkp_valid_i;
  logic             lkp_ready_o;
  logic [IDX_W-1:0] lkp_idx_i;
  logic [TAG_W-1:0] lkp_tag_i;
  logic             upd_en_i;
  logic [IDX_W-1:0] upd_idx_i;
  logic [WAY_W-1:0] upd_way_i;
  logic [TAG_W-1:0] upd_tag_i;
  logic             upd_valid_i;
  logic             rsp_valid_o;
  logic [WAYS-1:0]  rsp_hit_vec_o;
  logic             rsp_hit_o;
  logic [WAY_W-1:0] rsp_way_o;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  logic [TAG_W-1:0] ref_tag [SETS][WAYS];
  bit               ref_vld [SETS][WAYS];

  tagq_lookup #(
    .WAYS (WAYS), .SETS (SETS), .TAG_W (TAG_W), .IDX_W (IDX_W), .WAY_W (WAY_W)
  ) dut_i (
    .clk (clk), .rst_n (rst_n),
    .lkp_valid_i (lkp_valid_i), .lkp_ready_o (lkp_ready_o),
    .lkp_idx_i (lkp_idx_i), .lkp_tag_i (lkp_tag_i),
    .upd_en_i (upd_en_i), .upd_idx_i (upd_idx_i), .upd_way_i (upd_way_i),
    .upd_tag_i (upd_tag_i), .upd_valid_i (upd_valid_i),
    .rsp_valid_o (rsp_valid_o), .rsp_hit_vec_o (rsp_hit_vec_o),
    .rsp_hit_o (rsp_hit_o), .rsp_way_o (rsp_way_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [WAYS-1:0] exp_vec(input int unsigned idx,
                                              input logic [TAG_W-1:0] tag);
    logic [WAYS-1:0] v;
    int unsigned s;
    s = idx % SETS;
    for (int w = 0; w < WAYS; w++) v[w] = ref_vld[s][w] && (ref_tag[s][w] == tag);
    return v;
  endfunction

  function automatic logic [WAY_W-1:0] vec_way(input logic [WAYS-1:0] v);
    logic [WAY_W-1:0] r;
    r = '0;
    for (int w = 0; w < WAYS; w++) if (v[w]) r = WAY_W'(w);
    return r;
  endfunction

  // compare the response present now with an expected hit vector
  task automatic chk_rsp(input logic [WAYS-1:0] ev, input string req);
    chk(rsp_valid_o === 1'b1, req, "rsp_valid", 32'(rsp_valid_o), 1);
    chk(rsp_hit_vec_o === ev, req, "hit_vec", 32'(rsp_hit_vec_o), 32'(ev));
    chk(rsp_hit_o === (|ev), req, "hit", 32'(rsp_hit_o), 32'(|ev));
    if (|ev) chk(rsp_way_o === vec_way(ev), req, "way", 32'(rsp_way_o), 32'(vec_way(ev)));
  endtask

  // called at a negedge; returns at the next negedge
  task automatic upd(input int unsigned idx, input int unsigned way,
                     input logic [TAG_W-1:0] tag, input bit vld);
    upd_en_i = 1'b1; upd_idx_i = IDX_W'(idx); upd_way_i = WAY_W'(way);
    upd_tag_i = tag; upd_valid_i = vld;
    @(negedge clk);
    upd_en_i = 1'b0;
    ref_tag[idx % SETS][way] = tag;
    ref_vld[idx % SETS][way] = vld;
  endtask

  task automatic look(input int unsigned idx, input logic [TAG_W-1:0] tag,
                      input string req);
    logic [WAYS-1:0] ev;
    ev = exp_vec(idx, tag);
    lkp_valid_i = 1'b1; lkp_idx_i = IDX_W'(idx); lkp_tag_i = tag;
    @(negedge clk);
    lkp_valid_i = 1'b0;
    chk_rsp(ev, req);
  endtask

  task automatic t_reset_flush();
    int low_cnt;
    low_cnt = 0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(rsp_valid_o === 1'b0, "R1", "rsp_valid in reset", 32'(rsp_valid_o), 0);
    rst_n = 1'b1;
    lkp_valid_i = 1'b1; lkp_idx_i = '0; lkp_tag_i = '0;
    for (int i = 0; i < SETS + 4; i++) begin
      if (lkp_ready_o) break;
      low_cnt++;
      if (rsp_valid_o !== 1'b0)
        chk(1'b0, "R8", "response while not ready", 32'(rsp_valid_o), 0);
      @(negedge clk);
    end
    lkp_valid_i = 1'b0;
    chk(rsp_valid_o === 1'b0, "R8", "no response to flush-time request", 32'(rsp_valid_o), 0);
    chk(low_cnt == SETS, "R1", "ready-low cycles", 32'(low_cnt), SETS);
  endtask

  task automatic t_all_miss();
    for (int s = 0; s < SETS; s++) look(s, 8'h00, "R1");
    look(7, 8'h5a, "R1");
  endtask

  task automatic t_fill_hit();
    for (int w = 0; w < WAYS; w++) upd(3, w, TAG_W'(8'h10 + w), 1'b1);
    for (int w = 0; w < WAYS; w++) look(3, TAG_W'(8'h10 + w), "R4");
    look(3, 8'h99, "R4");
    look(4, 8'h11, "R6");
    upd(3, 2, 8'h77, 1'b1);
    look(3, 8'h10, "R6");
    look(3, 8'h11, "R6");
    look(3, 8'h13, "R6");
    look(3, 8'h77, "R9");
    look(3, 8'h12, "R6");
  endtask

  task automatic t_modulo();
    upd(9 + SETS, 1, 8'hc4, 1'b1);
    look(9, 8'hc4, "R2");
    look(9 + 2 * SETS, 8'hc4, "R2");
    look(10, 8'hc4, "R2");
  endtask

  task automatic t_invalidate();
    upd(3, 1, 8'h11, 1'b0);
    look(3, 8'h11, "R5");
    look(3, 8'h10, "R5");
    upd(12, 0, 8'h00, 1'b0);
    look(12, 8'h00, "R5");
  endtask

  task automatic t_same_cycle();
    logic [WAYS-1:0] ev_old;
    upd(5, 2, 8'h33, 1'b1);
    ev_old = exp_vec(5, 8'h33);
    lkp_valid_i = 1'b1; lkp_idx_i = 8'd5; lkp_tag_i = 8'h33;
    upd_en_i = 1'b1; upd_idx_i = 8'd5; upd_way_i = 2'd2;
    upd_tag_i = 8'h44; upd_valid_i = 1'b1;
    @(negedge clk);
    lkp_valid_i = 1'b0; upd_en_i = 1'b0;
    chk_rsp(ev_old, "R7");
    ref_tag[5][2] = 8'h44;
    look(5, 8'h44, "R7");
    look(5, 8'h33, "R7");
  endtask

  task automatic t_back_to_back();
    logic [WAYS-1:0] ea, eb, ec;
    upd(14, 3, 8'hab, 1'b1);
    ea = exp_vec(14, 8'hab);
    eb = exp_vec(14, 8'hac);
    ec = exp_vec(9, 8'hc4);
    lkp_valid_i = 1'b1; lkp_idx_i = 8'd14; lkp_tag_i = 8'hab;
    @(negedge clk);
    chk_rsp(ea, "R3");
    lkp_idx_i = 8'd14; lkp_tag_i = 8'hac;
    @(negedge clk);
    chk_rsp(eb, "R3");
    lkp_idx_i = 8'd9; lkp_tag_i = 8'hc4;
    @(negedge clk);
    chk_rsp(ec, "R3");
    lkp_valid_i = 1'b0;
    @(negedge clk);
    chk(rsp_valid_o === 1'b0, "R3", "single-cycle response", 32'(rsp_valid_o), 0);
    chk(rsp_hit_o === 1'b0 && rsp_hit_vec_o === '0, "R9", "idle hit outputs",
        32'(rsp_hit_vec_o), 0);
  endtask

  initial begin
    lkp_valid_i = 1'b0; lkp_idx_i = '0; lkp_tag_i = '0;
    upd_en_i = 1'b0; upd_idx_i = '0; upd_way_i = '0; upd_tag_i = '0; upd_valid_i = 1'b0;
    rst_n = 1'b0;
    for (int s = 0; s < SETS; s++)
      for (int w = 0; w < WAYS; w++) begin
        ref_tag[s][w] = '0;
        ref_vld[s][w] = 1'b0;
      end
    @(negedge clk);
    t_reset_flush();
    t_all_miss();
    t_fill_hit();
    t_modulo();
    t_invalidate();
    t_same_cycle();
    t_back_to_back();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule